// File: doc/BRIEF.md
# ATA Device-Side PIO and Interrupt Sequencer

This block is the protocol engine on the drive side of an ATA link. The task-file register decoder sits in front of it and sends one-cycle action pulses: command written, status read, drive-select written, 16-bit or 8-bit data access, soft-reset asserted or released. From these pulses the block drives the BSY, DRQ and DSC status bits and the INTRQ line. It runs PIO data-in and data-out transfers one block at a time through a 16-bit data port. Each block is staged in an internal sector buffer.

Sector reads and writes go to a storage backend over a request/acknowledge handshake. While the request is open the backend owns the sector buffer through its own address and data port. DMA commands are passed to an external DMA engine through an arm pulse, and the engine hands control back with a done or error pulse. The sequencer tracks whether its device is selected and whether an interrupt is outstanding. If its device is re-selected while an interrupt is still owed, the interrupt is raised again.

Top module: `ata_pio_fsm`

## Requirements
- R1: After reset bsy, drq, dsc and intrq are 0. With DEV_ID 0 the device comes up selected and accepts commands. With DEV_ID 1 it comes up not selected.
- R2: A non-data command (cmdKind 0) holds bsy at 1 for one cycle, then clears it. If nIen is 0, intrq rises and bmIntSet pulses in the same cycle. If nIen is 1, intrq stays 0.
- R3: While an interrupt is pending in the selected idle state, each of the following lowers intrq: a status read, nIen going to 1, or a new command. A new command also starts executing.
- R4: A select write naming the other device (selDev != DEV_ID) lowers intrq and remembers the owed interrupt. Commands are ignored while the device is not selected. Re-selecting it with nIen 0 raises intrq again and pulses bmIntSet.
- R5: A PIO read (cmdKind 2, sector count and start LBA taken with the command) raises stReq with stWrite 0 and stLba equal to the start LBA. bsy stays 1 until stAck. Then bsy goes to 0, drq goes to 1 and dataWord shows word 0 of the block. If nIen is 0, intrq rises, and data reads are ignored until a status read.
- R6: Each 16-bit data read advances dataWord by one word. At the end of a block that is not the last, bsy goes to 1, drq goes to 0 and the next LBA is requested. After the last block, bsy and drq are 0 and intrq stays 0. bsy and drq are never 1 together.
- R7: A sector count of 0 transfers 256 blocks.
- R8: An identify command (cmdKind 1) makes no storage request. It presents one block in which word i equals 16'hC000 | i.
- R9: A PIO write (cmdKind 3) raises drq for the first block at once, with no interrupt. Each full block raises stReq with stWrite 1 and sets bsy and dsc while clearing drq. Each later block raises intrq and waits for a status read. After the last block is acknowledged, the command completes with the R2 interrupt rule. The words stored in each block are the words written, in order.
- R10: A DMA command (cmdKind 4) holds bsy for one cycle. It then pulses dmaArm with bsy 0 and drq 1. dmaDone or dmaError pulses dmaRelease, sets dsc, clears bsy and drq, and applies the R2 interrupt rule.
- R11: An 8-bit data access pulses accessErr one cycle later and does not advance the transfer.
- R12: Asserting soft reset forces bsy to 1 and intrq to 0 from any state. Releasing it returns to the reset idle state with bsy 0.
- R13: protoErr, which flags an interrupt posted while one is already pending, never rises in legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| actCmdWrite | input | 1 | Command register written |
| cmdKind | input | 3 | Command class: 0 non-data, 1 identify, 2 PIO read, 3 PIO write, 4 DMA; 5-7 ignored |
| secCount | input | 8 | Sector count with the command (0 means 256) |
| lbaIn | input | LBA_W | Start LBA with the command |
| actStatRead | input | 1 | Status register read |
| actSelWrite | input | 1 | Drive-select register written |
| selDev | input | 1 | Device number in the select write |
| nIen | input | 1 | Interrupt disable level |
| actSrstSet | input | 1 | Soft reset asserted |
| actSrstClear | input | 1 | Soft reset released |
| actDataRd16 | input | 1 | 16-bit data read |
| actDataWr16 | input | 1 | 16-bit data write |
| actDataRd8 | input | 1 | 8-bit data read |
| actDataWr8 | input | 1 | 8-bit data write |
| wrData | input | 16 | Data word from the host |
| dataWord | output | 16 | Data word presented to the host |
| bsy | output | 1 | Busy status bit |
| drq | output | 1 | Data request status bit |
| dsc | output | 1 | Seek complete status bit |
| intrq | output | 1 | Interrupt request line |
| bmIntSet | output | 1 | Pulse that sets the interrupt bit in bus-master status |
| protoErr | output | 1 | Pulse: interrupt posted while pending |
| accessErr | output | 1 | Pulse: rejected 8-bit access |
| dmaArm | output | 1 | Pulse to start the DMA engine |
| dmaRelease | output | 1 | Pulse releasing the DMA engine |
| dmaDone | input | 1 | DMA transfer finished |
| dmaError | input | 1 | DMA transfer aborted |
| stReq | output | 1 | Storage request, held until stAck |
| stWrite | output | 1 | Storage direction, 1 = write sector |
| stLba | output | LBA_W | Storage sector address |
| stAck | input | 1 | Storage acknowledge pulse |
| stBufAddr | input | IDX_W | Backend word address into the sector buffer |
| stBufWe | input | 1 | Backend buffer write enable |
| stBufWdata | input | 16 | Backend buffer write data |
| stBufRdata | output | 16 | Backend buffer read data |

## Verification
The bench builds the block with WORDS_PER_BLOCK set to 4 and DEV_ID set to 0. With four words per block, multi-block reads and writes, block boundaries, and the 256-block case of a zero sector count all finish in a few thousand cycles. Under these values every last-word and last-block boundary occurs many times. Written data is checked against a queue filled by the host-write driver and drained by the storage model as it reads back each block.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [3:0] {
    ST_SRST, ST_IDLE_S, ST_IDLE_SI, ST_IDLE_NS, ST_EXEC,
    ST_PREP_IN, ST_INTR_IN, ST_XFER_IN,
    ST_PREP_OUT, ST_INTR_OUT, ST_XFER_OUT,
    ST_PREP_DMA, ST_XFER_DMA
  } devState_e;

  localparam logic [2:0] KIND_NODATA = 3'd0;
  localparam logic [2:0] KIND_IDENT  = 3'd1;
  localparam logic [2:0] KIND_PIO_IN = 3'd2;
  localparam logic [2:0] KIND_PIO_OUT = 3'd3;
  localparam logic [2:0] KIND_DMA    = 3'd4;

  typedef struct packed {
    logic loadCmd;
    logic ident;
    logic advance;
    logic hostWr;
    logic nextLba;
  } dpStrobe_t;
endpackage

// File: rtl/ata_pio_dpath.sv
module ata_pio_dpath
  import ata_pio_pkg::*;
#(
  parameter int WORDS_PER_BLOCK = 256,
  parameter int LBA_W = 28,
  localparam int IDX_W = $clog2(WORDS_PER_BLOCK),
  localparam int TOT_W = $clog2(256 * WORDS_PER_BLOCK) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [7:0]       secCount,
  input  logic [LBA_W-1:0] lbaIn,
  input  logic [15:0]      wrData,
  input  logic [IDX_W-1:0] stBufAddr,
  input  logic             stBufWe,
  input  logic [15:0]      stBufWdata,
  output logic [15:0]      stBufRdata,
  output logic [15:0]      dataWord,
  output logic [LBA_W-1:0] stLba,
  output logic             blkLast,
  output logic             totLast
);
  logic [IDX_W-1:0] wordIdx;
  logic [TOT_W-1:0] totLeft;
  logic             identMode;
  logic [15:0]      secBuf [WORDS_PER_BLOCK];

  assign blkLast = (wordIdx == IDX_W'(WORDS_PER_BLOCK - 1));
  assign totLast = (totLeft == TOT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx   <= '0;
      totLeft   <= '0;
      identMode <= 1'b0;
      stLba     <= '0;
    end else begin
      if (stb.loadCmd) begin
        wordIdx   <= '0;
        identMode <= stb.ident;
        stLba     <= lbaIn;
        if (stb.ident)
          totLeft <= TOT_W'(WORDS_PER_BLOCK);
        else if (secCount == 8'd0)
          totLeft <= TOT_W'(256 * WORDS_PER_BLOCK);
        else
          totLeft <= TOT_W'(secCount) * TOT_W'(WORDS_PER_BLOCK);
      end else if (stb.advance) begin
        wordIdx <= blkLast ? '0 : wordIdx + 1'b1;
        totLeft <= totLeft - 1'b1;
      end
      if (stb.nextLba) stLba <= stLba + 1'b1;
    end
  end

  // Host writes during DRQ phases, backend writes during BSY phases.
  always_ff @(posedge clk) begin
    if (stb.hostWr)
      secBuf[wordIdx] <= wrData;
    else if (stBufWe)
      secBuf[stBufAddr] <= stBufWdata;
  end

  assign stBufRdata = secBuf[stBufAddr];
  assign dataWord   = identMode ? (16'hC000 | 16'(wordIdx)) : secBuf[wordIdx];
endmodule

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
  import ata_pio_pkg::*;
#(
  parameter int DEV_ID = 0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      actCmdWrite,
  input  logic [2:0] cmdKind,
  input  logic      actStatRead,
  input  logic      actSelWrite,
  input  logic      selDev,
  input  logic      nIen,
  input  logic      actSrstSet,
  input  logic      actSrstClear,
  input  logic      actDataRd16,
  input  logic      actDataWr16,
  input  logic      actDataRd8,
  input  logic      actDataWr8,
  input  logic      dmaDone,
  input  logic      dmaError,
  input  logic      stAck,
  input  logic      blkLast,
  input  logic      totLast,
  output dpStrobe_t stb,
  output logic      bsy,
  output logic      drq,
  output logic      dsc,
  output logic      intrq,
  output logic      bmIntSet,
  output logic      protoErr,
  output logic      accessErr,
  output logic      dmaArm,
  output logic      dmaRelease,
  output logic      stReq,
  output logic      stWrite
);
  localparam devState_e INIT_ST = (DEV_ID == 0) ? ST_IDLE_S : ST_IDLE_NS;

  devState_e state, stateN;
  logic bsyN, drqN, dscN, intrqN, heldN, reqN, wrN, finN, identN;
  logic held, finalBlk, isIdent;
  logic post, arm, rel, start, finish, selMe;

  assign selMe = (selDev == 1'(DEV_ID));

  always_comb begin
    stateN = state; bsyN = bsy; drqN = drq; dscN = dsc; intrqN = intrq;
    heldN = held; reqN = stReq; wrN = stWrite; finN = finalBlk; identN = isIdent;
    post = 1'b0; arm = 1'b0; rel = 1'b0; start = 1'b0; finish = 1'b0;
    stb = '0;
    if (actSrstSet) begin
      stateN = ST_SRST; bsyN = 1'b1; drqN = 1'b0; intrqN = 1'b0;
      heldN = 1'b0; reqN = 1'b0;
    end else begin
      unique case (state)
        ST_SRST: if (actSrstClear) begin
          stateN = INIT_ST; bsyN = 1'b0; dscN = 1'b0;
        end
        ST_IDLE_S:
          if (actSelWrite && !selMe) stateN = ST_IDLE_NS;
          else if (actCmdWrite) start = 1'b1;
        ST_IDLE_SI:
          if (actSelWrite && !selMe) begin
            stateN = ST_IDLE_NS; intrqN = 1'b0; heldN = 1'b1;
          end else if (actStatRead || nIen) begin
            stateN = ST_IDLE_S; intrqN = 1'b0;
          end else if (actCmdWrite) begin
            intrqN = 1'b0; start = 1'b1;
          end
        ST_IDLE_NS:
          if (actSelWrite && selMe) begin
            heldN = 1'b0;
            if (held && !nIen) begin stateN = ST_IDLE_SI; post = 1'b1; end
            else stateN = ST_IDLE_S;
          end
        ST_EXEC: finish = 1'b1;
        ST_PREP_IN:
          if (isIdent || stAck) begin
            reqN = 1'b0; bsyN = 1'b0; drqN = 1'b1; stb.nextLba = stAck;
            if (!nIen) begin stateN = ST_INTR_IN; post = 1'b1; end
            else stateN = ST_XFER_IN;
          end
        ST_INTR_IN:
          if (actStatRead) begin stateN = ST_XFER_IN; intrqN = 1'b0; end
        ST_XFER_IN:
          if (actDataRd16) begin
            stb.advance = 1'b1;
            if (blkLast) begin
              drqN = 1'b0;
              if (totLast) begin bsyN = 1'b0; stateN = ST_IDLE_S; end
              else begin bsyN = 1'b1; reqN = 1'b1; wrN = 1'b0; stateN = ST_PREP_IN; end
            end
          end
        ST_PREP_OUT:
          if (stAck) begin
            reqN = 1'b0; stb.nextLba = 1'b1;
            if (finalBlk) finish = 1'b1;
            else begin
              bsyN = 1'b0; drqN = 1'b1;
              if (!nIen) begin stateN = ST_INTR_OUT; post = 1'b1; end
              else stateN = ST_XFER_OUT;
            end
          end
        ST_INTR_OUT:
          if (actStatRead) begin stateN = ST_XFER_OUT; intrqN = 1'b0; end
        ST_XFER_OUT:
          if (actDataWr16) begin
            stb.hostWr = 1'b1; stb.advance = 1'b1;
            if (blkLast) begin
              bsyN = 1'b1; dscN = 1'b1; drqN = 1'b0; reqN = 1'b1; wrN = 1'b1;
              finN = totLast; stateN = ST_PREP_OUT;
            end
          end
        ST_PREP_DMA: begin
          bsyN = 1'b0; drqN = 1'b1; arm = 1'b1; stateN = ST_XFER_DMA;
        end
        ST_XFER_DMA:
          if (dmaDone || dmaError) begin rel = 1'b1; dscN = 1'b1; finish = 1'b1; end
        default: stateN = INIT_ST;
      endcase
    end

    if (start && cmdKind <= KIND_DMA) begin
      stb.loadCmd = 1'b1; stb.ident = (cmdKind == KIND_IDENT);
      identN = (cmdKind == KIND_IDENT);
      bsyN = 1'b1; drqN = 1'b0; dscN = 1'b0; finN = 1'b0;
      case (cmdKind)
        KIND_NODATA: stateN = ST_EXEC;
        KIND_IDENT:  stateN = ST_PREP_IN;
        KIND_PIO_IN: begin stateN = ST_PREP_IN; reqN = 1'b1; wrN = 1'b0; end
        KIND_PIO_OUT: begin stateN = ST_XFER_OUT; bsyN = 1'b0; drqN = 1'b1; end
        default:     stateN = ST_PREP_DMA;
      endcase
    end else if (start) begin
      stateN = ST_IDLE_S;
    end
    if (finish) begin
      bsyN = 1'b0; drqN = 1'b0;
      if (!nIen) begin stateN = ST_IDLE_SI; post = 1'b1; end
      else stateN = ST_IDLE_S;
    end
    if (post) intrqN = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= INIT_ST; bsy <= 1'b0; drq <= 1'b0; dsc <= 1'b0; intrq <= 1'b0;
      held <= 1'b0; stReq <= 1'b0; stWrite <= 1'b0; finalBlk <= 1'b0; isIdent <= 1'b0;
      bmIntSet <= 1'b0; protoErr <= 1'b0; accessErr <= 1'b0;
      dmaArm <= 1'b0; dmaRelease <= 1'b0;
    end else begin
      state <= stateN; bsy <= bsyN; drq <= drqN; dsc <= dscN; intrq <= intrqN;
      held <= heldN; stReq <= reqN; stWrite <= wrN; finalBlk <= finN; isIdent <= identN;
      bmIntSet   <= post;
      protoErr   <= post && intrq;
      accessErr  <= actDataRd8 || actDataWr8;
      dmaArm     <= arm;
      dmaRelease <= rel;
    end
  end
endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int WORDS_PER_BLOCK = 256,
  parameter int LBA_W = 28,
  parameter int DEV_ID = 0,
  localparam int IDX_W = $clog2(WORDS_PER_BLOCK)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             actCmdWrite,
  input  logic [2:0]       cmdKind,
  input  logic [7:0]       secCount,
  input  logic [LBA_W-1:0] lbaIn,
  input  logic             actStatRead,
  input  logic             actSelWrite,
  input  logic             selDev,
  input  logic             nIen,
  input  logic             actSrstSet,
  input  logic             actSrstClear,
  input  logic             actDataRd16,
  input  logic             actDataWr16,
  input  logic             actDataRd8,
  input  logic             actDataWr8,
  input  logic [15:0]      wrData,
  output logic [15:0]      dataWord,
  output logic             bsy,
  output logic             drq,
  output logic             dsc,
  output logic             intrq,
  output logic             bmIntSet,
  output logic             protoErr,
  output logic             accessErr,
  output logic             dmaArm,
  output logic             dmaRelease,
  input  logic             dmaDone,
  input  logic             dmaError,
  output logic             stReq,
  output logic             stWrite,
  output logic [LBA_W-1:0] stLba,
  input  logic             stAck,
  input  logic [IDX_W-1:0] stBufAddr,
  input  logic             stBufWe,
  input  logic [15:0]      stBufWdata,
  output logic [15:0]      stBufRdata
);
  dpStrobe_t stb;
  logic blkLast, totLast;

  ata_pio_ctrl #(.DEV_ID(DEV_ID)) ctrl_i (
    .clk(clk), .rstN(rstN), .actCmdWrite(actCmdWrite), .cmdKind(cmdKind),
    .actStatRead(actStatRead), .actSelWrite(actSelWrite), .selDev(selDev),
    .nIen(nIen), .actSrstSet(actSrstSet), .actSrstClear(actSrstClear),
    .actDataRd16(actDataRd16), .actDataWr16(actDataWr16),
    .actDataRd8(actDataRd8), .actDataWr8(actDataWr8),
    .dmaDone(dmaDone), .dmaError(dmaError), .stAck(stAck),
    .blkLast(blkLast), .totLast(totLast), .stb(stb),
    .bsy(bsy), .drq(drq), .dsc(dsc), .intrq(intrq), .bmIntSet(bmIntSet),
    .protoErr(protoErr), .accessErr(accessErr), .dmaArm(dmaArm),
    .dmaRelease(dmaRelease), .stReq(stReq), .stWrite(stWrite)
  );

  ata_pio_dpath #(.WORDS_PER_BLOCK(WORDS_PER_BLOCK), .LBA_W(LBA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .secCount(secCount), .lbaIn(lbaIn),
    .wrData(wrData), .stBufAddr(stBufAddr), .stBufWe(stBufWe),
    .stBufWdata(stBufWdata), .stBufRdata(stBufRdata), .dataWord(dataWord),
    .stLba(stLba), .blkLast(blkLast), .totLast(totLast)
  );
endmodule

// File: rtl/ata_pio_chk.sv
module ata_pio_chk (
  input logic clk,
  input logic rstN,
  input logic bsy,
  input logic drq,
  input logic intrq,
  input logic bmIntSet,
  input logic protoErr,
  input logic dmaArm,
  input logic stReq,
  input logic actDataRd8,
  input logic actDataWr8,
  input logic accessErr,
  input logic actSrstSet
);
  AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(bsy && drq)); // R6
  AST_INT_POST: assert property (@(posedge clk) disable iff (!rstN) $rose(intrq) |-> bmIntSet); // R2
  AST_POST_RAISES: assert property (@(posedge clk) disable iff (!rstN) bmIntSet |-> intrq); // R4
  AST_NO_PROTO_ERR: assert property (@(posedge clk) disable iff (!rstN) !protoErr); // R13
  AST_ARM_STATUS: assert property (@(posedge clk) disable iff (!rstN) dmaArm |-> (drq && !bsy)); // R10
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rstN) stReq |-> bsy); // R5
  AST_BYTE_REJECT: assert property (@(posedge clk) disable iff (!rstN) (actDataRd8 || actDataWr8) |=> accessErr); // R11
  AST_SRST_FORCE: assert property (@(posedge clk) disable iff (!rstN) actSrstSet |=> (bsy && !intrq)); // R12
endmodule

bind ata_pio_fsm ata_pio_chk chk_i (
  .clk(clk), .rstN(rstN), .bsy(bsy), .drq(drq), .intrq(intrq),
  .bmIntSet(bmIntSet), .protoErr(protoErr), .dmaArm(dmaArm), .stReq(stReq),
  .actDataRd8(actDataRd8), .actDataWr8(actDataWr8), .accessErr(accessErr),
  .actSrstSet(actSrstSet)
);

// File: tb/ata_pio_fsm_tb_top.sv
module ata_pio_fsm_tb_top;
  localparam int W = 4;
  localparam int LW = 28;
  localparam int IW = $clog2(W);

  logic clk = 1'b0, rstN = 1'b0;
  logic actCmdWrite = 0, actStatRead = 0, actSelWrite = 0, selDev = 0, nIen = 0;
  logic actSrstSet = 0, actSrstClear = 0, actDataRd16 = 0, actDataWr16 = 0;
  logic actDataRd8 = 0, actDataWr8 = 0, dmaDone = 0, dmaError = 0, stAck = 0, stBufWe = 0;
  logic [2:0] cmdKind = 0;
  logic [7:0] secCount = 0;
  logic [LW-1:0] lbaIn = 0;
  logic [15:0] wrData = 0, stBufWdata = 0;
  logic [IW-1:0] stBufAddr = 0;
  logic [15:0] dataWord, stBufRdata;
  logic bsy, drq, dsc, intrq, bmIntSet, protoErr, accessErr, dmaArm, dmaRelease, stReq, stWrite;
  logic [LW-1:0] stLba;

  int checks = 0, failures = 0, reqCount = 0, wrBlocks = 0;
  logic protoSeen = 1'b0;
  logic [15:0] expQ[$];

  always #2 clk = ~clk;

  ata_pio_fsm #(.WORDS_PER_BLOCK(W), .LBA_W(LW), .DEV_ID(0)) dut_i (.*);

  function automatic logic [15:0] pat(input logic [LW-1:0] lba, input int i);
    return {lba[7:0], 8'(i)} ^ 16'h3300;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Storage backend model; drains written blocks against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (stReq) begin
        reqCount++;
        if (!stWrite) begin
          for (int i = 0; i < W; i++) begin
            stBufAddr = IW'(i); stBufWdata = pat(stLba, i); stBufWe = 1'b1;
            @(negedge clk);
          end
          stBufWe = 1'b0;
        end else begin
          wrBlocks++;
          for (int i = 0; i < W; i++) begin
            stBufAddr = IW'(i);
            #1;
            if (expQ.size() == 0) chk("R9 queue", 32'(stBufRdata), 32'hFFFF_FFFF);
            else chk("R9 stored word", 32'(stBufRdata), 32'(expQ.pop_front()));
            @(negedge clk);
          end
        end
        stAck = 1'b1;
        @(negedge clk);
        stAck = 1'b0;
      end
    end
  end

  always @(posedge clk) if (rstN && protoErr) protoSeen <= 1'b1;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic cmd(input logic [2:0] k, input logic [7:0] c, input logic [LW-1:0] l);
    @(negedge clk); cmdKind = k; secCount = c; lbaIn = l; actCmdWrite = 1;
    @(negedge clk); actCmdWrite = 0;
  endtask
  task automatic statRead();
    @(negedge clk); actStatRead = 1; @(negedge clk); actStatRead = 0;
  endtask
  task automatic selWrite(input logic d);
    @(negedge clk); selDev = d; actSelWrite = 1; @(negedge clk); actSelWrite = 0;
  endtask
  task automatic rd16(input string req, input logic [15:0] exp);
    @(negedge clk); chk(req, 32'(dataWord), 32'(exp)); actDataRd16 = 1;
    @(negedge clk); actDataRd16 = 0;
  endtask
  task automatic wr16(input logic [15:0] d);
    @(negedge clk); wrData = d; actDataWr16 = 1; expQ.push_back(d);
    @(negedge clk); actDataWr16 = 0;
  endtask
  task automatic waitDrq();
    for (int t = 0; t < 100; t++) begin
      if (drq && !bsy) return;
      @(negedge clk);
    end
    chk("drq wait", 0, 1);
  endtask
  task automatic waitIdle();
    for (int t = 0; t < 100; t++) begin
      if (!bsy) return;
      @(negedge clk);
    end
    chk("idle wait", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rc, blocks;
    cyc(4); rstN = 1; cyc(1);
    chk("R1 bsy", 32'(bsy), 0); chk("R1 drq", 32'(drq), 0);
    chk("R1 dsc", 32'(dsc), 0); chk("R1 intrq", 32'(intrq), 0);

    // R2 non-data with interrupts enabled
    cmd(0, 1, 0);
    chk("R1 R2 bsy during exec", 32'(bsy), 1);
    cyc(1);
    chk("R2 bsy cleared", 32'(bsy), 0); chk("R2 intrq", 32'(intrq), 1);
    chk("R2 bmIntSet", 32'(bmIntSet), 1);
    statRead();
    chk("R3 status read clears", 32'(intrq), 0);
    nIen = 1; cmd(0, 1, 0); cyc(2);
    chk("R2 masked no intrq", 32'(intrq), 0);
    nIen = 0;

    // R4 selection
    cmd(0, 1, 0); cyc(1);
    chk("R4 intrq before deselect", 32'(intrq), 1);
    selWrite(1);
    chk("R4 deselect drops intrq", 32'(intrq), 0);
    cmd(0, 1, 0);
    chk("R4 command ignored", 32'(bsy), 0);
    selWrite(0);
    chk("R4 reselect intrq", 32'(intrq), 1);
    chk("R4 reselect bmIntSet", 32'(bmIntSet), 1);
    nIen = 1; cyc(1);
    chk("R3 nIen clears", 32'(intrq), 0);
    nIen = 0;

    // R3 new command clears and starts; R5/R6 PIO read
    cmd(0, 1, 0); cyc(1);
    rc = reqCount;
    cmd(2, 2, 100);
    chk("R3 command clears", 32'(intrq), 0);
    chk("R5 stReq", 32'(stReq), 1); chk("R5 stWrite", 32'(stWrite), 0);
    chk("R5 stLba", 32'(stLba), 100); chk("R5 bsy held", 32'(bsy), 1);
    waitDrq();
    chk("R5 intrq", 32'(intrq), 1);
    chk("R5 word0", 32'(dataWord), 32'(pat(100, 0)));
    @(negedge clk); actDataRd16 = 1; @(negedge clk); actDataRd16 = 0;
    chk("R5 read ignored before status", 32'(dataWord), 32'(pat(100, 0)));
    statRead();
    for (int i = 0; i < W; i++) rd16("R6 block0 word", pat(100, i));
    chk("R6 mid bsy", 32'(bsy), 1); chk("R6 mid drq", 32'(drq), 0);
    waitDrq(); statRead();
    rd16("R6 block1 word", pat(101, 0));
    rd16("R6 block1 word", pat(101, 1));
    @(negedge clk); actDataRd8 = 1; @(negedge clk); actDataRd8 = 0;
    chk("R11 accessErr", 32'(accessErr), 1);
    chk("R11 no advance", 32'(dataWord), 32'(pat(101, 2)));
    rd16("R6 block1 word", pat(101, 2));
    rd16("R6 block1 word", pat(101, 3));
    chk("R6 end bsy", 32'(bsy), 0); chk("R6 end drq", 32'(drq), 0);
    chk("R6 end no intrq", 32'(intrq), 0);
    chk("R5 request count", 32'(reqCount - rc), 2);

    // R8 identify
    rc = reqCount;
    cmd(1, 0, 0); waitDrq(); statRead();
    for (int i = 0; i < W; i++) rd16("R8 ident word", 16'hC000 | 16'(i));
    chk("R8 no storage request", 32'(reqCount - rc), 0);

    // R9 PIO write
    wrBlocks = 0;
    cmd(3, 2, 200);
    chk("R9 first drq", 32'(drq), 1); chk("R9 first no intrq", 32'(intrq), 0);
    for (int i = 0; i < W; i++) wr16(16'hA000 + 16'(i));
    chk("R9 block bsy", 32'(bsy), 1); chk("R9 dsc", 32'(dsc), 1);
    chk("R9 stWrite", 32'(stWrite), 1); chk("R9 stLba", 32'(stLba), 200);
    waitDrq();
    chk("R9 later block intrq", 32'(intrq), 1);
    statRead();
    for (int i = 0; i < W; i++) wr16(16'hB100 + 16'(i));
    cyc(1); waitIdle();
    chk("R9 completion intrq", 32'(intrq), 1); chk("R9 drq off", 32'(drq), 0);
    chk("R9 blocks stored", 32'(wrBlocks), 2);
    chk("R9 queue drained", 32'(expQ.size()), 0);
    statRead();

    // R7 sector count zero, interrupts masked
    nIen = 1; blocks = 0;
    cmd(2, 0, 1000);
    for (int b = 0; b < 256; b++) begin
      waitDrq(); blocks++;
      for (int i = 0; i < W; i++) rd16("R7 word", pat(LW'(1000 + b), i));
    end
    chk("R7 blocks", 32'(blocks), 256);
    chk("R7 done bsy", 32'(bsy), 0); chk("R7 no intrq", 32'(intrq), 0);
    nIen = 0;

    // R10 DMA
    cmd(4, 1, 0);
    chk("R10 bsy", 32'(bsy), 1);
    cyc(1);
    chk("R10 dmaArm", 32'(dmaArm), 1); chk("R10 drq", 32'(drq), 1);
    cyc(2);
    @(negedge clk); dmaDone = 1; @(negedge clk); dmaDone = 0;
    chk("R10 release", 32'(dmaRelease), 1); chk("R10 dsc", 32'(dsc), 1);
    chk("R10 drq off", 32'(drq), 0); chk("R10 intrq", 32'(intrq), 1);
    statRead();
    cmd(4, 1, 0); cyc(2);
    @(negedge clk); dmaError = 1; @(negedge clk); dmaError = 0;
    chk("R10 error release", 32'(dmaRelease), 1);
    statRead();

    // R12 soft reset
    cmd(0, 1, 0); cyc(1);
    @(negedge clk); actSrstSet = 1; @(negedge clk); actSrstSet = 0;
    chk("R12 bsy forced", 32'(bsy), 1); chk("R12 intrq dropped", 32'(intrq), 0);
    @(negedge clk); actSrstClear = 1; @(negedge clk); actSrstClear = 0;
    chk("R12 released bsy", 32'(bsy), 0);
    cmd(0, 1, 0); cyc(1);
    chk("R12 R1 selected after release", 32'(intrq), 1);
    statRead();

    cyc(4);
    chk("R13 protoErr never", 32'(protoSeen), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule